// File: doc/BRIEF.md
# Packet Radio Mode Auto-Return Controller

This block keeps the three operating-mode enable bits of a packet radio: transmit enable, receive enable and synthesizer enable. From these bits it derives the active radio state, which is Idle, Tune, TX or RX. The host sets the bits through a simple write port and can read them back at any time. Five event pulses come in from the packet handler: packet sent, valid packet received, CRC error, header error and sync error.

When the modulation data source is the on-chip FIFO, the controller ends a transfer by itself. A packet-sent event clears the transmit enable, and a valid-packet event clears the receive enable. The state then falls back to whatever the remaining bits select. Receive errors never end reception; they only raise interrupt flags, and the host decides what happens next. With any other data source, events change no mode bit, and TX or RX stays active until the host clears it.

Each event also sets a sticky interrupt flag. A flag-read strobe clears all the flags.

Top module: `radio_mode_ctrl`

## Requirements
- R1: After reset the state is Idle (2'b00), all three mode bits read 0 and all interrupt flags read 0.
- R2: A write loads the three mode bits. The read-back bits and the state change on the clock edge that samples the write. The state encoding is Idle 2'b00, Tune 2'b01, TX 2'b10 and RX 2'b11. If only synth is set the state is Tune, if only rx is set it is RX, and if no bit is set it is Idle.
- R3: When tx and rx are both set, the state is TX and rx stays set in the read-back. Once tx clears, the state becomes RX.
- R4: With the data source in FIFO mode (src_sel = 2'b10), a packet-sent event in TX clears only tx. The state then goes to Tune if synth is set, and to Idle if no other bit is set.
- R5: In FIFO mode, a valid-packet event while the state is RX clears only rx. The state then becomes Tune if synth is set, and Idle otherwise.
- R6: CRC, header and sync error events leave rx set and the state in RX.
- R7: With any data source other than FIFO (src_sel 2'b00, 2'b01 or 2'b11), no event changes a mode bit or the state.
- R8: Each event sets its own sticky flag, whatever the data source. The flag bits are: bit 0 packet sent, bit 1 valid packet, bit 2 CRC error, bit 3 header error, bit 4 sync error. A flag stays set until it is read.
- R9: A flag-read strobe clears all flags on the next edge. An event that arrives in the same cycle as the strobe leaves its flag set.
- R10: A host write in the same cycle as a completion event wins. The written bits are loaded as given, and the event clears nothing.
- R11: A packet-sent event while not in TX, or a valid-packet event while not in RX, changes no mode bit and does not change the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Mode-bit write strobe |
| wr_tx | input | 1 | Transmit enable value to write |
| wr_rx | input | 1 | Receive enable value to write |
| wr_synth | input | 1 | Synthesizer enable value to write |
| src_sel | input | 2 | Modulation data source (2'b10 = FIFO) |
| evt_sent | input | 1 | Packet-sent pulse |
| evt_valid | input | 1 | Valid-packet-received pulse |
| evt_crc_err | input | 1 | CRC error pulse |
| evt_hdr_err | input | 1 | Header error pulse |
| evt_sync_err | input | 1 | Sync error pulse |
| flag_rd | input | 1 | Flag read strobe, clears the flags |
| state | output | 2 | Active state |
| mode_tx | output | 1 | Transmit enable read-back |
| mode_rx | output | 1 | Receive enable read-back |
| mode_synth | output | 1 | Synthesizer enable read-back |
| irq_flags | output | 5 | Sticky interrupt flags |

## Verification
The assertions check the following on every cycle:
- TX always wins over RX in the state.
- A FIFO-mode packet-sent event clears tx, and a valid-packet event in RX clears rx.
- Error events never move the state out of RX.
- Outside FIFO mode the mode bits hold unless the host writes them.
- A host write loads exactly what was written.
- Flags stay set until a read, and a read with no event leaves them all clear.

Only the bench scenarios can show the state each fallback lands in: Tune or Idle after a transmit, and RX after a transmit that had rx pending. The scenarios also cover:
- events that are ignored in PN9 and pin-driven modes;
- events that arrive in the wrong state;
- which flag bit each event sets.

// File: rtl/radio_mode_pkg.sv
package radio_mode_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_TUNE = 2'b01,
        ST_TX   = 2'b10,
        ST_RX   = 2'b11
    } radio_state_e;

    typedef struct packed {
        logic synth;
        logic rx;
        logic tx;
    } mode_bits_t;

    localparam logic [1:0] SRC_FIFO = 2'b10;

    localparam int NUM_EVT      = 5;
    localparam int EVT_SENT     = 0;
    localparam int EVT_VALID    = 1;
    localparam int EVT_CRC_ERR  = 2;
    localparam int EVT_HDR_ERR  = 3;
    localparam int EVT_SYNC_ERR = 4;

endpackage

// File: rtl/mode_bits_reg.sv
module mode_bits_reg
    import radio_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  mode_bits_t wr_bits,
    input  logic       fifo_mode,
    input  logic       evt_sent,
    input  logic       evt_valid,
    output mode_bits_t bits_d,
    output mode_bits_t bits_q
);

    always_comb begin
        bits_d = bits_q;
        if (wr_en) begin
            bits_d = wr_bits;
        end else if (fifo_mode) begin
            if (bits_q.tx && evt_sent) begin
                bits_d.tx = 1'b0;
            end else if (!bits_q.tx && bits_q.rx && evt_valid) begin
                bits_d.rx = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    // R4: packet sent in FIFO-mode TX ends transmission
    assert_sent_clears_tx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode && !wr_en && bits_q.tx && evt_sent) |=> (!bits_q.tx && bits_q.synth == $past(bits_q.synth)));

    // R5: valid packet in FIFO-mode RX ends reception
    assert_valid_clears_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode && !wr_en && !bits_q.tx && bits_q.rx && evt_valid) |=> !bits_q.rx);

    // R7: outside FIFO mode only the host moves the bits
    assert_nonfifo_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_mode && !wr_en) |=> (bits_q == $past(bits_q)));

    // R10: a write loads exactly the written value
    assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (bits_q == $past(wr_bits)));

endmodule

// File: rtl/state_track.sv
module state_track
    import radio_mode_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  mode_bits_t   bits_d,
    output radio_state_e state_q
);

    radio_state_e state_d;

    always_comb begin
        if (bits_d.tx)         state_d = ST_TX;
        else if (bits_d.rx)    state_d = ST_RX;
        else if (bits_d.synth) state_d = ST_TUNE;
        else                   state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         rd_clr,
    output logic [N-1:0] flags_q
);

    logic [N-1:0] flags_d;

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_comb flags_d[i] = evt[i] | (flags_q[i] & ~rd_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    // R8: a flag stays set until it is read
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R9: a read with no new event clears all flags
    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && evt == '0) |=> (flags_q == '0));

endmodule

// File: rtl/radio_mode_ctrl.sv
module radio_mode_ctrl
    import radio_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_tx,
    input  logic       wr_rx,
    input  logic       wr_synth,
    input  logic [1:0] src_sel,
    input  logic       evt_sent,
    input  logic       evt_valid,
    input  logic       evt_crc_err,
    input  logic       evt_hdr_err,
    input  logic       evt_sync_err,
    input  logic       flag_rd,
    output logic [1:0] state,
    output logic       mode_tx,
    output logic       mode_rx,
    output logic       mode_synth,
    output logic [4:0] irq_flags
);

    mode_bits_t       wr_bits;
    mode_bits_t       bits_d;
    mode_bits_t       bits_q;
    radio_state_e     state_q;
    logic [NUM_EVT-1:0] evt_vec;
    logic             fifo_mode;

    always_comb begin
        wr_bits.tx    = wr_tx;
        wr_bits.rx    = wr_rx;
        wr_bits.synth = wr_synth;
        fifo_mode     = (src_sel == SRC_FIFO);
        evt_vec                = '0;
        evt_vec[EVT_SENT]      = evt_sent;
        evt_vec[EVT_VALID]     = evt_valid;
        evt_vec[EVT_CRC_ERR]   = evt_crc_err;
        evt_vec[EVT_HDR_ERR]   = evt_hdr_err;
        evt_vec[EVT_SYNC_ERR]  = evt_sync_err;
    end

    mode_bits_reg u_bits (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_bits   (wr_bits),
        .fifo_mode (fifo_mode),
        .evt_sent  (evt_sent),
        .evt_valid (evt_valid),
        .bits_d    (bits_d),
        .bits_q    (bits_q)
    );

    state_track u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .bits_d  (bits_d),
        .state_q (state_q)
    );

    irq_flag_bank #(.N(NUM_EVT)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt_vec),
        .rd_clr  (flag_rd),
        .flags_q (irq_flags)
    );

    assign state      = state_q;
    assign mode_tx    = bits_q.tx;
    assign mode_rx    = bits_q.rx;
    assign mode_synth = bits_q.synth;

    // R3: transmit enable always selects TX
    assert_tx_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_tx |-> (state == ST_TX));

    // R6: receive errors never end reception
    assert_err_keeps_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RX && !wr_en && !evt_valid && (evt_crc_err || evt_hdr_err || evt_sync_err))
        |=> (state == ST_RX && mode_rx));

endmodule

// File: tb/radio_mode_ctrl_test.sv
module radio_mode_ctrl_test;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_tx = 1'b0, wr_rx = 1'b0, wr_synth = 1'b0;
    logic [1:0] src_sel = 2'b10;
    logic       evt_sent = 1'b0, evt_valid = 1'b0, evt_crc_err = 1'b0;
    logic       evt_hdr_err = 1'b0, evt_sync_err = 1'b0, flag_rd = 1'b0;
    logic [1:0] state;
    logic       mode_tx, mode_rx, mode_synth;
    logic [4:0] irq_flags;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    radio_mode_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tx(wr_tx), .wr_rx(wr_rx),
        .wr_synth(wr_synth), .src_sel(src_sel), .evt_sent(evt_sent),
        .evt_valid(evt_valid), .evt_crc_err(evt_crc_err), .evt_hdr_err(evt_hdr_err),
        .evt_sync_err(evt_sync_err), .flag_rd(flag_rd), .state(state),
        .mode_tx(mode_tx), .mode_rx(mode_rx), .mode_synth(mode_synth),
        .irq_flags(irq_flags)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // bits checked as {synth, rx, tx}
    task automatic check_mode(input string req, input logic [1:0] st, input logic [2:0] bits);
        check(req, {30'd0, state}, {30'd0, st});
        check(req, {29'd0, mode_synth, mode_rx, mode_tx}, {29'd0, bits});
    endtask

    // one-cycle stimulus: drive at negedge, release at next negedge
    task automatic step(input logic we, input logic [2:0] wb, input logic [4:0] ev, input logic rd);
        @(negedge clk);
        wr_en = we; {wr_synth, wr_rx, wr_tx} = wb;
        {evt_sync_err, evt_hdr_err, evt_crc_err, evt_valid, evt_sent} = ev;
        flag_rd = rd;
        @(negedge clk);
        wr_en = 1'b0; {wr_synth, wr_rx, wr_tx} = 3'b000;
        {evt_sync_err, evt_hdr_err, evt_crc_err, evt_valid, evt_sent} = 5'b0;
        flag_rd = 1'b0;
    endtask

    task automatic wr(input logic [2:0] wb);
        step(1'b1, wb, 5'b0, 1'b0);
    endtask

    task automatic ev(input logic [4:0] e);
        step(1'b0, 3'b000, e, 1'b0);
    endtask

    task automatic clear_flags();
        step(1'b0, 3'b000, 5'b0, 1'b1);
    endtask

    task automatic t_reset();
        check_mode("R1 reset", 2'b00, 3'b000);
        check("R1 flags", {27'd0, irq_flags}, 32'd0);
    endtask

    task automatic t_write();
        src_sel = 2'b10;
        wr(3'b100); check_mode("R2 synth only -> Tune", 2'b01, 3'b100);
        wr(3'b010); check_mode("R2 rx only -> RX", 2'b11, 3'b010);
        wr(3'b000); check_mode("R2 none -> Idle", 2'b00, 3'b000);
    endtask

    task automatic t_priority();
        src_sel = 2'b10;
        wr(3'b011); check_mode("R3 tx+rx -> TX", 2'b10, 3'b011);
        ev(5'b00001); check_mode("R3 tx cleared -> RX", 2'b11, 3'b010);
        ev(5'b00010); check_mode("R5 valid -> Idle", 2'b00, 3'b000);
    endtask

    task automatic t_tx_return();
        src_sel = 2'b10;
        wr(3'b101); ev(5'b00001);
        check_mode("R4 sent with synth -> Tune", 2'b01, 3'b100);
        wr(3'b001); ev(5'b00001);
        check_mode("R4 sent tx only -> Idle", 2'b00, 3'b000);
        wr(3'b110); ev(5'b00010);
        check_mode("R5 valid with synth -> Tune", 2'b01, 3'b100);
    endtask

    task automatic t_rx_errors();
        src_sel = 2'b10;
        clear_flags();
        wr(3'b010);
        ev(5'b00100); check_mode("R6 crc keeps RX", 2'b11, 3'b010);
        ev(5'b01000); check_mode("R6 hdr keeps RX", 2'b11, 3'b010);
        ev(5'b10000); check_mode("R6 sync keeps RX", 2'b11, 3'b010);
        check("R8 error flags bits 2..4", {27'd0, irq_flags}, 32'h1C);
        ev(5'b00010); check_mode("R5 valid ends RX", 2'b00, 3'b000);
    endtask

    task automatic t_direct();
        clear_flags();
        src_sel = 2'b00;
        wr(3'b001); ev(5'b00001);
        check_mode("R7 pin source keeps TX", 2'b10, 3'b001);
        src_sel = 2'b11;
        wr(3'b010); ev(5'b00010);
        check_mode("R7 PN9 source keeps RX", 2'b11, 3'b010);
        src_sel = 2'b01;
        wr(3'b001); ev(5'b00001);
        check_mode("R7 serial source keeps TX", 2'b10, 3'b001);
        check("R8 flags set outside FIFO", {27'd0, irq_flags}, 32'h03);
        wr(3'b000);
    endtask

    task automatic t_ignored();
        src_sel = 2'b10;
        wr(3'b010); ev(5'b00001);
        check_mode("R11 sent in RX ignored", 2'b11, 3'b010);
        wr(3'b100); ev(5'b00010);
        check_mode("R11 valid in Tune ignored", 2'b01, 3'b100);
        wr(3'b011); ev(5'b00010);
        check_mode("R11 valid in TX ignored", 2'b10, 3'b011);
        wr(3'b000);
    endtask

    task automatic t_flags();
        ev(5'b00001);
        check("R8 sent flag bit 0", {27'd0, irq_flags[0]}, 32'd1);
        clear_flags();
        check("R9 read clears", {27'd0, irq_flags}, 32'd0);
        ev(5'b01000);
        step(1'b0, 3'b000, 5'b00100, 1'b1);
        check("R9 event during read kept", {27'd0, irq_flags}, 32'h04);
        clear_flags();
    endtask

    task automatic t_write_wins();
        src_sel = 2'b10;
        wr(3'b001);
        step(1'b1, 3'b101, 5'b00001, 1'b0);
        check_mode("R10 write beats sent", 2'b10, 3'b101);
        wr(3'b010);
        step(1'b1, 3'b010, 5'b00010, 1'b0);
        check_mode("R10 write beats valid", 2'b11, 3'b010);
        wr(3'b000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_write();
        t_priority();
        t_tx_return();
        t_rx_errors();
        t_direct();
        t_ignored();
        t_flags();
        t_write_wins();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule